// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the read and write command strobes of an IDE/ATA task-file access. A host-side agent raises a one-cycle start request naming the drive and the direction. The block then holds the matching active-low strobe of that drive's channel for a programmed active time, releases it for a programmed recovery time and reports completion with a one-cycle done pulse. The clock period is the timing unit, so each count is a whole number of clocks. Software computes each count by rounding the required nanoseconds up to whole clocks. The recovery count is the cycle time less the active time.

Each drive owns a 16-bit timing word. Bits [15:8] hold the active clock count minus one, bits [5:0] hold the recovery clock count minus one, and bit 6 asks that a low IORDY from the drive stretch the active phase. Each channel has two control bits in an 8-bit control byte: an enable at bit 4·c and a fast-timing select at bit 4·c+1. When the select is clear, the channel ignores the programmed words and uses a fixed slowest-mode word. A disabled channel never strobes. All timing is captured when a request is accepted, so register writes act on the next access only.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: After reset every read strobe and write strobe is high (inactive), done is low, all timing words are 0 and the control byte is 0.
- R2: With the channel enabled and its fast-timing bit set, the selected strobe is low for exactly (word[15:8]+1) consecutive clocks, starting the clock after the accepted request.
- R3: After the strobe rises it stays high for exactly (word[5:0]+1) clocks, and done is high in the clock that follows; word bit 7 has no effect.
- R4: A request with write=1 lowers only the write strobe of the drive's channel; write=0 lowers only its read strobe; all other strobes stay high.
- R5: When the channel's fast-timing bit (control bit 4·c+1) is clear, the access uses the fixed fallback word (default 0x050D: 6 active, 14 recovery clocks, IORDY not honoured) regardless of the drive's programmed word.
- R6: When the channel's enable bit (control bit 4·c) is clear, an accepted request lowers no strobe and done is high in the clock after acceptance.
- R7: When the timing in use has bit 6 set, each clock of the active phase in which the channel's IORDY input is low adds one clock to the active phase; with bit 6 clear, IORDY has no effect.
- R8: done is a single-clock pulse; a start request seen while an access is in progress is ignored and causes no further strobe or done.
- R9: A timing or control write made during an access does not change that access; the next access uses the new value.
- R10: Drive d uses its own timing word and belongs to channel d / DRV_PER_CH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period is the timing unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| tim_we | input | 1 | Timing word write strobe |
| tim_drive | input | DRV_W | Drive whose timing word is written |
| tim_wdata | input | 16 | Timing word value |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 4·NUM_CH | Control byte value |
| req_start | input | 1 | One-cycle access request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_drive | input | DRV_W | Target drive of the access |
| iordy | input | NUM_CH | Per-channel IORDY from the drives (high = ready) |
| dior_n | output | NUM_CH | Per-channel active-low read strobe |
| diow_n | output | NUM_CH | Per-channel active-low write strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default build: two channels with two drives each and the 0x050D fallback word. This covers drives that share a channel and drives on different channels, which checks that channel mapping and strobe isolation agree with the drive index. It covers one channel in fallback timing while the other uses programmed timing, and a disabled channel beside an enabled one. With an 8-bit active field and a 6-bit recovery field, the bench can use both the minimum of one clock and the 6/14-clock fallback within short runs.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

  localparam int TWORD_W      = 16;
  localparam int ACT_W        = 8;
  localparam int REC_W        = 6;
  localparam int HONOUR_BIT   = 6;
  localparam int CTL_STRIDE   = 4;
  localparam int CTL_EN_OFS   = 0;
  localparam int CTL_MODE_OFS = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_REC  = 2'd2
  } seq_st_t;

  typedef struct packed {
    logic             en;
    logic             honour;
    logic [ACT_W-1:0] act_m1;
    logic [REC_W-1:0] rec_m1;
  } acc_tim_t;

endpackage

// File: rtl/ide_pio_regs.sv
module ide_pio_regs
  import ide_pio_pkg::*;
#(
  parameter int NUM_DRV = 4,
  parameter int DRV_W   = 2,
  parameter int CTL_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tim_we,
  input  logic [DRV_W-1:0]           tim_drive,
  input  logic [TWORD_W-1:0]         tim_wdata,
  input  logic                       ctl_we,
  input  logic [CTL_W-1:0]           ctl_wdata,
  output logic [NUM_DRV*TWORD_W-1:0] tim_flat,
  output logic [CTL_W-1:0]           ctl_q
);

  logic [NUM_DRV-1:0][TWORD_W-1:0] tim_q;
  logic [NUM_DRV-1:0]              tim_wen;

  always_comb begin
    for (int d = 0; d < NUM_DRV; d++) begin
      tim_wen[d] = tim_we && (tim_drive == DRV_W'(d));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q <= '0;
    end else begin
      for (int d = 0; d < NUM_DRV; d++) begin
        if (tim_wen[d]) tim_q[d] <= tim_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata;
  end

  generate
    for (genvar g = 0; g < NUM_DRV; g++) begin : g_flat
      assign tim_flat[g*TWORD_W +: TWORD_W] = tim_q[g];
    end
  endgenerate

  // R9: control byte changes only on a write
  p_ctl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_q));

endmodule

// File: rtl/ide_pio_tsel.sv
module ide_pio_tsel
  import ide_pio_pkg::*;
#(
  parameter int                 NUM_DRV       = 4,
  parameter int                 DRV_PER_CH    = 2,
  parameter int                 DRV_W         = 2,
  parameter int                 CH_W          = 1,
  parameter int                 CTL_W         = 8,
  parameter logic [TWORD_W-1:0] FALLBACK_WORD = 16'h050D
) (
  input  logic [DRV_W-1:0]           drv,
  input  logic [NUM_DRV*TWORD_W-1:0] tim_flat,
  input  logic [CTL_W-1:0]           ctl,
  output acc_tim_t                   tim,
  output logic [CH_W-1:0]            ch
);

  always_comb begin
    automatic int            chi  = int'(drv) / DRV_PER_CH;
    automatic logic [TWORD_W-1:0] word = tim_flat[int'(drv)*TWORD_W +: TWORD_W];
    automatic logic          fast = ctl[chi*CTL_STRIDE + CTL_MODE_OFS];
    automatic logic [TWORD_W-1:0] use_w = fast ? word : FALLBACK_WORD;
    ch         = CH_W'(chi);
    tim.en     = ctl[chi*CTL_STRIDE + CTL_EN_OFS];
    tim.honour = use_w[HONOUR_BIT];
    tim.act_m1 = use_w[TWORD_W-1 -: ACT_W];
    tim.rec_m1 = use_w[REC_W-1:0];
  end

endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [CH_W-1:0]   req_ch,
  input  acc_tim_t          tim,
  input  logic [NUM_CH-1:0] iordy,
  output logic [NUM_CH-1:0] dior_n,
  output logic [NUM_CH-1:0] diow_n,
  output logic              done
);

  seq_st_t          st_q, st_d;
  logic [ACT_W-1:0] cnt_q, cnt_d;
  logic [REC_W-1:0] rec_q;
  logic             wr_q, honour_q;
  logic [CH_W-1:0]  ch_q;
  logic             done_q, done_d;
  logic             cap_en;
  logic             iordy_sel;
  logic             stall;

  assign cap_en    = (st_q == ST_IDLE) && req_start;
  assign iordy_sel = iordy[ch_q];
  assign stall     = honour_q && !iordy_sel;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_start) begin
          if (tim.en) begin
            st_d  = ST_ACT;
            cnt_d = tim.act_m1;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_ACT: begin
        if (!stall) begin
          if (cnt_q == '0) begin
            st_d  = ST_REC;
            cnt_d = ACT_W'(rec_q);
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
      ST_REC: begin
        if (cnt_q == '0) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q    <= '0;
      wr_q     <= 1'b0;
      honour_q <= 1'b0;
      ch_q     <= '0;
    end else if (cap_en) begin
      rec_q    <= tim.rec_m1;
      wr_q     <= req_write;
      honour_q <= tim.honour;
      ch_q     <= req_ch;
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
      assign dior_n[c] = !((st_q == ST_ACT) && !wr_q && (ch_q == CH_W'(c)));
      assign diow_n[c] = !((st_q == ST_ACT) &&  wr_q && (ch_q == CH_W'(c)));
    end
  endgenerate

  assign done = done_q;

  // R1: no strobe outside the active phase
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_ACT) |-> (&dior_n && &diow_n));

  // R4: at most one strobe low at any time
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~dior_n, ~diow_n}) <= 1);

  // R8: done lasts one clock
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a request during an access does not restart it
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REC && cnt_q != '0 && req_start) |=> (st_q == ST_REC));

  // R7: a stalled active phase keeps its count
  p_iordy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACT && stall) |=> (st_q == ST_ACT && $stable(cnt_q)));

  // R9: captured access settings stay fixed while busy
  p_snapshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |->
      ($stable(rec_q) && $stable(wr_q) && $stable(ch_q) && $stable(honour_q)));

  // R2: active count never grows inside one active phase
  p_act_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACT && $past(st_q) == ST_ACT) |-> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/ide_pio_strobe_gen.sv
module ide_pio_strobe_gen
  import ide_pio_pkg::*;
#(
  parameter int                 NUM_CH        = 2,
  parameter int                 DRV_PER_CH    = 2,
  parameter logic [TWORD_W-1:0] FALLBACK_WORD = 16'h050D,
  localparam int                NUM_DRV       = NUM_CH * DRV_PER_CH,
  localparam int                DRV_W         = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1,
  localparam int                CH_W          = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int                CTL_W         = CTL_STRIDE * NUM_CH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tim_we,
  input  logic [DRV_W-1:0]   tim_drive,
  input  logic [TWORD_W-1:0] tim_wdata,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic               req_start,
  input  logic               req_write,
  input  logic [DRV_W-1:0]   req_drive,
  input  logic [NUM_CH-1:0]  iordy,
  output logic [NUM_CH-1:0]  dior_n,
  output logic [NUM_CH-1:0]  diow_n,
  output logic               done
);

  logic [NUM_DRV*TWORD_W-1:0] tim_flat;
  logic [CTL_W-1:0]           ctl_q;
  acc_tim_t                   sel_tim;
  logic [CH_W-1:0]            sel_ch;

  ide_pio_regs #(
    .NUM_DRV (NUM_DRV),
    .DRV_W   (DRV_W),
    .CTL_W   (CTL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .tim_we    (tim_we),
    .tim_drive (tim_drive),
    .tim_wdata (tim_wdata),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .tim_flat  (tim_flat),
    .ctl_q     (ctl_q)
  );

  ide_pio_tsel #(
    .NUM_DRV       (NUM_DRV),
    .DRV_PER_CH    (DRV_PER_CH),
    .DRV_W         (DRV_W),
    .CH_W          (CH_W),
    .CTL_W         (CTL_W),
    .FALLBACK_WORD (FALLBACK_WORD)
  ) u_tsel (
    .drv      (req_drive),
    .tim_flat (tim_flat),
    .ctl      (ctl_q),
    .tim      (sel_tim),
    .ch       (sel_ch)
  );

  ide_pio_seq #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .req_write (req_write),
    .req_ch    (sel_ch),
    .tim       (sel_tim),
    .iordy     (iordy),
    .dior_n    (dior_n),
    .diow_n    (diow_n),
    .done      (done)
  );

endmodule

// File: tb/ide_pio_strobe_gen_test.sv
module ide_pio_strobe_gen_test;

  logic        clk;
  logic        rst_n;
  logic        tim_we;
  logic [1:0]  tim_drive;
  logic [15:0] tim_wdata;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic        req_start;
  logic        req_write;
  logic [1:0]  req_drive;
  logic [1:0]  iordy;
  logic [1:0]  dior_n;
  logic [1:0]  diow_n;
  logic        done;

  int n_chk;
  int n_bad;

  ide_pio_strobe_gen uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tim_we    (tim_we),
    .tim_drive (tim_drive),
    .tim_wdata (tim_wdata),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .req_start (req_start),
    .req_write (req_write),
    .req_drive (req_drive),
    .iordy     (iordy),
    .dior_n    (dior_n),
    .diow_n    (diow_n),
    .done      (done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // results of the last access
  int         m_act, m_rec, m_done, m_post;
  logic [1:0] m_rd, m_wr;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_tim(input int d, input logic [15:0] w);
    @(negedge clk);
    tim_we = 1'b1; tim_drive = 2'(d); tim_wdata = w;
    @(negedge clk);
    tim_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] w);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // Starts an access at a falling edge and samples every falling edge after.
  task automatic run_access(input int d, input bit wr, input int k_iordy,
                            input bit extra_req, input bit mid_wr,
                            input logic [15:0] mid_word);
    int s;
    bit fin;
    m_act = 0; m_rec = 0; m_done = 0; m_post = 0; m_rd = 2'b00; m_wr = 2'b00;
    @(negedge clk);
    iordy     = (k_iordy > 0) ? 2'b00 : 2'b11;
    req_start = 1'b1; req_write = wr; req_drive = 2'(d);
    s = 0; fin = 1'b0;
    while (!fin && s < 2000) begin
      @(negedge clk);
      s++;
      req_start = 1'b0;
      tim_we    = 1'b0;
      if (k_iordy > 0 && s == k_iordy + 1) iordy = 2'b11;
      if (extra_req && s == 2) req_start = 1'b1;
      if (mid_wr && s == 2) begin
        tim_we = 1'b1; tim_drive = 2'(d); tim_wdata = mid_word;
      end
      m_rd = m_rd | ~dior_n;
      m_wr = m_wr | ~diow_n;
      if (done) begin
        m_done = 1; fin = 1'b1;
      end else if ((&dior_n) && (&diow_n)) begin
        if (m_act > 0) m_rec++;
      end else begin
        m_act++;
      end
    end
    req_start = 1'b0;
    tim_we    = 1'b0;
    iordy     = 2'b11;
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      if (done) m_done++;
      if (!((&dior_n) && (&diow_n))) m_post++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 read strobes high",  int'(dior_n), 3);
    chk("R1 write strobes high", int'(diow_n), 3);
    chk("R1 done low",           int'(done),   0);
    // control byte 0 after reset: channel 0 disabled, no strobe
    run_access(0, 1'b0, 0, 1'b0, 1'b0, 16'h0);
    chk("R1 ctl reset -> no strobe", m_act, 0);
  endtask

  task automatic t_prog();
    wr_ctl(8'h33);
    wr_tim(0, 16'h0302);
    wr_tim(1, 16'h0185);
    wr_tim(2, 16'h0000);
    run_access(0, 1'b0, 0, 1'b0, 1'b0, 16'h0);
    chk("R2 active drive0",   m_act, 4);
    chk("R3 recovery drive0", m_rec, 3);
    chk("R4 read strobe ch0", int'(m_rd), 1);
    chk("R4 no write strobe", int'(m_wr), 0);
    run_access(1, 1'b1, 0, 1'b0, 1'b0, 16'h0);
    chk("R10 active drive1",          m_act, 2);
    chk("R3 bit7 ignored recovery",   m_rec, 6);
    chk("R4 write strobe ch0",        int'(m_wr), 1);
    chk("R4 no read strobe on write", int'(m_rd), 0);
    run_access(2, 1'b0, 0, 1'b0, 1'b0, 16'h0);
    chk("R2 minimum active drive2", m_act, 1);
    chk("R3 minimum recovery",      m_rec, 1);
    chk("R10 drive2 on ch1",        int'(m_rd), 2);
  endtask

  task automatic t_fallback();
    wr_tim(0, 16'h0342);
    wr_ctl(8'h31);
    run_access(0, 1'b0, 3, 1'b0, 1'b0, 16'h0);
    chk("R5 fallback active",         m_act, 6);
    chk("R5 fallback recovery",       m_rec, 14);
    run_access(2, 1'b1, 0, 1'b0, 1'b0, 16'h0);
    chk("R5 other channel programmed", m_act, 1);
  endtask

  task automatic t_disabled();
    wr_ctl(8'h03);
    run_access(3, 1'b0, 0, 1'b0, 1'b0, 16'h0);
    chk("R6 no read strobe",  int'(m_rd), 0);
    chk("R6 no write strobe", int'(m_wr), 0);
    chk("R6 done seen",       m_done, 1);
    chk("R6 no active",       m_act, 0);
  endtask

  task automatic t_iordy();
    wr_ctl(8'h33);
    wr_tim(3, 16'h0241);
    wr_tim(2, 16'h0201);
    run_access(3, 1'b0, 4, 1'b0, 1'b0, 16'h0);
    chk("R7 stretched active",   m_act, 7);
    chk("R7 recovery unchanged", m_rec, 2);
    run_access(2, 1'b0, 4, 1'b0, 1'b0, 16'h0);
    chk("R7 iordy ignored without flag", m_act, 3);
  endtask

  task automatic t_busy();
    run_access(0, 1'b0, 0, 1'b1, 1'b0, 16'h0);
    chk("R8 active unchanged", m_act, 4);
    chk("R8 single done",      m_done, 1);
    chk("R8 no strobe after done", m_post, 0);
  endtask

  task automatic t_midwrite();
    wr_tim(1, 16'h0102);
    run_access(1, 1'b1, 0, 1'b0, 1'b1, 16'h0505);
    chk("R9 current active kept",   m_act, 2);
    chk("R9 current recovery kept", m_rec, 3);
    run_access(1, 1'b1, 0, 1'b0, 1'b0, 16'h0);
    chk("R9 next active new",   m_act, 6);
    chk("R9 next recovery new", m_rec, 6);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    tim_we = 1'b0; tim_drive = 2'd0; tim_wdata = 16'h0;
    ctl_we = 1'b0; ctl_wdata = 8'h0;
    req_start = 1'b0; req_write = 1'b0; req_drive = 2'd0;
    iordy = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prog();
    t_fallback();
    t_disabled();
    t_iordy();
    t_busy();
    t_midwrite();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule